// File: doc/BRIEF.md
# Bus Failure Mode Manager

This block is the control core of a two-wire, fault-tolerant, low-speed CAN line interface. It watches digitised comparator results from the analog front end and decides how the node reaches the bus. The outputs are the two driver enables, a strong or weak setting for each termination, the receiver path (differential, CANH wire only, or CANL wire only) and an active-low wiring-fault flag. The comparators report a CANH over-voltage, a CANL over-voltage, a persistent dominant differential level, a recessive differential level, and one-cycle pulse marks for edges seen on each wire.

Each fault class uses its own confirmation time and its own recovery time. All of these are counted in ticks of an external prescaled enable. A CANH short to a supply is handled in two steps. The first time-out moves reception to the CANH wire. A second time-out, with the comparator still asserted, moves reception to CANL, switches the CANH driver off and weakens the RTH termination. Open wires and benign shorts do not change the bus path. They are found by comparing the edge counts of the two wires, and they only drive the fault flag. The detector works only while the node is in normal operating mode. In any other mode its state is frozen.

Top module: `bus_fail_mgr`

## Requirements
- R1: After a synchronous reset, and whenever no failure is confirmed, rxMode is 0 (differential; 1 = CANH only, 2 = CANL only, 3 never appears), drvHEn, drvLEn, rthStrong and rtlStrong are 1, and errN is 1.
- R2: When canhHigh is held for H1_TICKS enabled ticks, rxMode becomes 1 and errN becomes 0. The drivers and terminations do not change.
- R3: When canhHigh stays asserted for a further H2_TICKS ticks after the first step, rxMode becomes 2, and drvHEn and rthStrong become 0.
- R4: From either CANH step, canhHigh held low for HREC_TICKS ticks restores the full differential setting.
- R5: A qualifying input that drops before its time-out expires restarts that count from zero.
- R6: When canlHigh is held for L6_TICKS ticks, rxMode becomes 1, drvLEn, rtlStrong and errN become 0. When canlHigh is then held low for L6REC_TICKS ticks, the setting recovers.
- R7: When domPersist is held for DOM_TICKS ticks, drvLEn, rtlStrong and errN become 0 and rxMode becomes 1. When recessive is then held for DOMREC_TICKS ticks, the setting recovers.
- R8: When the pulse count on one wire gets OPEN_DIFF ahead of the other, errN becomes 0. A pulse on both wires in the same cycle counts for neither wire. The drivers, terminations and rxMode stay unchanged.
- R9: An open-wire flag clears after OPEN_REC consecutive pulses that fall on both wires in the same cycle. A pulse on one wire alone restarts that run.
- R10: While normalMode is 0, no comparator input or pulse changes any output, and the confirmed state is held.
- R11: When more than one single-wire failure is confirmed, rxMode follows the failure confirmed most recently. If that failure recovers, rxMode falls back in the order CANH fault, CANL high, persistent dominant.
- R12: Time-outs advance only in cycles where tickEn is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | Prescaled time base enable |
| normalMode | input | 1 | Node is in normal operating mode |
| canhHigh | input | 1 | CANH above its short-circuit level |
| canlHigh | input | 1 | CANL above its short-circuit level |
| domPersist | input | 1 | Differential level persistently dominant |
| recessive | input | 1 | Differential level recessive |
| pulseH | input | 1 | Edge pulse seen on CANH |
| pulseL | input | 1 | Edge pulse seen on CANL |
| drvHEn | output | 1 | CANH driver enable |
| drvLEn | output | 1 | CANL driver enable |
| rthStrong | output | 1 | RTH termination strong (0 = weak pull-down) |
| rtlStrong | output | 1 | RTL termination strong (0 = weak pull-up) |
| rxMode | output | 2 | Receiver path: 0 differential, 1 CANH, 2 CANL |
| errN | output | 1 | Wiring fault flag, active low |

## Verification
Every output is a registered function of the confirmed failure state, so a wrong internal state shows up at the ports in the cycle right after the bad update. It appears as a wrong rxMode, a wrong driver or termination setting, or an errN mismatch. A counter that is off by one only shows up on the edge where a time-out should fire, one tick early or late. For this reason the reference model is compared in every cycle, while tickEn is gated irregularly. A stale recency record stays hidden until two single-wire faults overlap and one of them recovers, so that ordering is driven on purpose.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {RX_DIFF = 2'd0, RX_CANH = 2'd1, RX_CANL = 2'd2} rxSel_e;
  typedef enum logic [1:0] {SRC_NONE = 2'd0, SRC_HIGH = 2'd1, SRC_L6 = 2'd2, SRC_L47 = 2'd3} src_e;

  typedef struct packed {
    logic hStep;
    logic hRec;
    logic lHighFire;
    logic domFire;
    logic openSet;
    logic openClr;
  } fmStrobe_t;

  typedef struct packed {
    logic [1:0] hStage;
    logic       lHighOn;
    logic       domOn;
    logic       openOn;
  } fmState_t;
endpackage

// File: rtl/fm_timer.sv
module fm_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tickEn,
  input  logic [CW-1:0] limit,
  output logic          fire
);
  logic [CW-1:0] cnt;
  logic          atEnd;

  assign atEnd = (cnt == limit - CW'(1));
  assign fire  = run && tickEn && atEnd;

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (tickEn)  cnt <= atEnd ? '0 : cnt + CW'(1);
  end
endmodule

// File: rtl/fm_datapath.sv
module fm_datapath
  import fm_pkg::*;
#(
  parameter int H1_TICKS     = 200,
  parameter int H2_TICKS     = 200,
  parameter int HREC_TICKS   = 50,
  parameter int L6_TICKS     = 50,
  parameter int L6REC_TICKS  = 25,
  parameter int DOM_TICKS    = 50,
  parameter int DOMREC_TICKS = 2,
  parameter int OPEN_DIFF    = 4,
  parameter int OPEN_REC     = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tickEn,
  input  logic      normalMode,
  input  logic      canhHigh,
  input  logic      canlHigh,
  input  logic      domPersist,
  input  logic      recessive,
  input  logic      pulseH,
  input  logic      pulseL,
  input  fmState_t  st,
  output fmStrobe_t stb
);
  localparam int MAX_A = (H1_TICKS > H2_TICKS) ? H1_TICKS : H2_TICKS;
  localparam int MAX_B = (HREC_TICKS > L6_TICKS) ? HREC_TICKS : L6_TICKS;
  localparam int MAX_C = (L6REC_TICKS > DOM_TICKS) ? L6REC_TICKS : DOM_TICKS;
  localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_E = (MAX_C > DOMREC_TICKS) ? MAX_C : DOMREC_TICKS;
  localparam int MAXT  = (MAX_D > MAX_E) ? MAX_D : MAX_E;
  localparam int CW    = $clog2(MAXT + 1);
  localparam int NT    = 4;
  localparam int DW    = $clog2(OPEN_DIFF + 1) + 1;
  localparam int RW    = $clog2(OPEN_REC + 1);
  localparam logic signed [DW-1:0] DLIM = DW'(OPEN_DIFF);

  logic [NT-1:0] tRun;
  logic [NT-1:0] tFire;
  logic [CW-1:0] tLim [NT];

  // timer 0: CANH escalation, 1: CANH recovery, 2: CANL high, 3: dominant/recessive
  always_comb begin
    tRun[0] = normalMode && (st.hStage != 2'd2) && canhHigh;
    tLim[0] = (st.hStage == 2'd0) ? CW'(H1_TICKS) : CW'(H2_TICKS);
    tRun[1] = normalMode && (st.hStage != 2'd0) && !canhHigh;
    tLim[1] = CW'(HREC_TICKS);
    tRun[2] = normalMode && (st.lHighOn ? !canlHigh : canlHigh);
    tLim[2] = st.lHighOn ? CW'(L6REC_TICKS) : CW'(L6_TICKS);
    tRun[3] = normalMode && (st.domOn ? recessive : domPersist);
    tLim[3] = st.domOn ? CW'(DOMREC_TICKS) : CW'(DOM_TICKS);
  end

  for (genvar i = 0; i < NT; i++) begin : gTimer
    fm_timer #(.CW(CW)) uTimer (
      .clk(clk), .rst(rst), .run(tRun[i]), .tickEn(tickEn),
      .limit(tLim[i]), .fire(tFire[i])
    );
  end

  // open-wire pulse balance
  logic signed [DW-1:0] pulseDiff, diffStep, diffNext;
  logic [RW-1:0]        bothRun;
  logic                 bothPulse, anyPulse;

  always_comb begin
    bothPulse = pulseH && pulseL;
    anyPulse  = pulseH || pulseL;
    if (pulseH && !pulseL)      diffStep = DW'(1);
    else if (pulseL && !pulseH) diffStep = -DW'(1);
    else                        diffStep = '0;
    diffNext = pulseDiff + diffStep;
  end

  always_comb begin
    stb.hStep     = tFire[0];
    stb.hRec      = tFire[1];
    stb.lHighFire = tFire[2];
    stb.domFire   = tFire[3];
    stb.openSet   = normalMode && !st.openOn && ((diffNext == DLIM) || (diffNext == -DLIM));
    stb.openClr   = normalMode && st.openOn && bothPulse && (bothRun == RW'(OPEN_REC - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || !normalMode) begin
      pulseDiff <= '0;
      bothRun   <= '0;
    end else if (!st.openOn) begin
      pulseDiff <= stb.openSet ? '0 : diffNext;
      bothRun   <= '0;
    end else begin
      pulseDiff <= '0;
      if (bothPulse)     bothRun <= stb.openClr ? '0 : bothRun + RW'(1);
      else if (anyPulse) bothRun <= '0;
    end
  end
endmodule

// File: rtl/fm_control.sv
module fm_control
  import fm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  fmStrobe_t stb,
  output fmState_t  st,
  output logic      drvHEn,
  output logic      drvLEn,
  output logic      rthStrong,
  output logic      rtlStrong,
  output logic [1:0] rxMode,
  output logic      errN
);
  src_e   lastSrc;
  src_e   pick;
  rxSel_e rxSel;
  logic   hOn;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= '0;
      lastSrc <= SRC_NONE;
    end else begin
      if (stb.hStep) begin
        st.hStage <= st.hStage + 2'd1;
        lastSrc   <= SRC_HIGH;
      end
      if (stb.hRec) st.hStage <= 2'd0;
      if (stb.lHighFire) begin
        st.lHighOn <= !st.lHighOn;
        if (!st.lHighOn) lastSrc <= SRC_L6;
      end
      if (stb.domFire) begin
        st.domOn <= !st.domOn;
        if (!st.domOn) lastSrc <= SRC_L47;
      end
      if (stb.openSet) st.openOn <= 1'b1;
      if (stb.openClr) st.openOn <= 1'b0;
    end
  end

  always_comb begin
    hOn = (st.hStage != 2'd0);
    if ((lastSrc == SRC_HIGH && hOn) || (lastSrc == SRC_L6 && st.lHighOn) ||
        (lastSrc == SRC_L47 && st.domOn)) pick = lastSrc;
    else if (hOn)        pick = SRC_HIGH;
    else if (st.lHighOn) pick = SRC_L6;
    else if (st.domOn)   pick = SRC_L47;
    else                 pick = SRC_NONE;
    case (pick)
      SRC_HIGH: rxSel = (st.hStage == 2'd2) ? RX_CANL : RX_CANH;
      SRC_L6:   rxSel = RX_CANH;
      SRC_L47:  rxSel = RX_CANH;
      default:  rxSel = RX_DIFF;
    endcase
    rxMode    = rxSel;
    drvHEn    = (st.hStage != 2'd2);
    rthStrong = (st.hStage != 2'd2);
    drvLEn    = !(st.lHighOn || st.domOn);
    rtlStrong = !(st.lHighOn || st.domOn);
    errN      = !(hOn || st.lHighOn || st.domOn || st.openOn);
  end
endmodule

// File: rtl/bus_fail_mgr.sv
module bus_fail_mgr
  import fm_pkg::*;
#(
  parameter int H1_TICKS     = 200,
  parameter int H2_TICKS     = 200,
  parameter int HREC_TICKS   = 50,
  parameter int L6_TICKS     = 50,
  parameter int L6REC_TICKS  = 25,
  parameter int DOM_TICKS    = 50,
  parameter int DOMREC_TICKS = 2,
  parameter int OPEN_DIFF    = 4,
  parameter int OPEN_REC     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tickEn,
  input  logic       normalMode,
  input  logic       canhHigh,
  input  logic       canlHigh,
  input  logic       domPersist,
  input  logic       recessive,
  input  logic       pulseH,
  input  logic       pulseL,
  output logic       drvHEn,
  output logic       drvLEn,
  output logic       rthStrong,
  output logic       rtlStrong,
  output logic [1:0] rxMode,
  output logic       errN
);
  fmStrobe_t stb;
  fmState_t  st;

  fm_datapath #(
    .H1_TICKS(H1_TICKS), .H2_TICKS(H2_TICKS), .HREC_TICKS(HREC_TICKS),
    .L6_TICKS(L6_TICKS), .L6REC_TICKS(L6REC_TICKS), .DOM_TICKS(DOM_TICKS),
    .DOMREC_TICKS(DOMREC_TICKS), .OPEN_DIFF(OPEN_DIFF), .OPEN_REC(OPEN_REC)
  ) uPath (
    .clk(clk), .rst(rst), .tickEn(tickEn), .normalMode(normalMode),
    .canhHigh(canhHigh), .canlHigh(canlHigh), .domPersist(domPersist),
    .recessive(recessive), .pulseH(pulseH), .pulseL(pulseL), .st(st), .stb(stb)
  );

  fm_control uCtrl (
    .clk(clk), .rst(rst), .stb(stb), .st(st), .drvHEn(drvHEn), .drvLEn(drvLEn),
    .rthStrong(rthStrong), .rtlStrong(rtlStrong), .rxMode(rxMode), .errN(errN)
  );
endmodule

// File: rtl/fm_checker.sv
module fm_checker (
  input logic       clk,
  input logic       rst,
  input logic       tickEn,
  input logic       normalMode,
  input logic       pulseH,
  input logic       pulseL,
  input logic       drvHEn,
  input logic       drvLEn,
  input logic       rthStrong,
  input logic       rtlStrong,
  input logic [1:0] rxMode,
  input logic       errN
);
  AST_RX_LEGAL: assert property (@(posedge clk) disable iff (rst) rxMode != 2'd3); // R1
  AST_SINGLE_FLAGS: assert property (@(posedge clk) disable iff (rst) (rxMode != 2'd0) |-> !errN); // R2
  AST_HDRV_FLAGS: assert property (@(posedge clk) disable iff (rst) !drvHEn |-> (!errN && rxMode != 2'd0)); // R3
  AST_LDRV_FLAGS: assert property (@(posedge clk) disable iff (rst) !rtlStrong |-> (!errN && !drvLEn)); // R7
  AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !normalMode |=> ($stable(rxMode) && $stable(errN) && $stable(drvHEn) && $stable(drvLEn)
                     && $stable(rthStrong) && $stable(rtlStrong))); // R10
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tickEn && !pulseH && !pulseL) |=> ($stable(rxMode) && $stable(errN) && $stable(drvHEn)
                                        && $stable(drvLEn))); // R12
endmodule

bind bus_fail_mgr fm_checker uChk (
  .clk(clk), .rst(rst), .tickEn(tickEn), .normalMode(normalMode), .pulseH(pulseH),
  .pulseL(pulseL), .drvHEn(drvHEn), .drvLEn(drvLEn), .rthStrong(rthStrong),
  .rtlStrong(rtlStrong), .rxMode(rxMode), .errN(errN)
);

// File: tb/tb_bus_fail_mgr.sv
`timescale 1ns/1ps
module tb_bus_fail_mgr;
  localparam int H1 = 200, H2 = 200, HREC = 50, L6 = 50, L6R = 25, DOM = 50, DOMR = 2;
  localparam int ODIFF = 4, OREC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1, tickEn = 1'b0, normalMode = 1'b1;
  logic canhHigh = 1'b0, canlHigh = 1'b0, domPersist = 1'b0, recessive = 1'b0;
  logic pulseH = 1'b0, pulseL = 1'b0;
  logic drvHEn, drvLEn, rthStrong, rtlStrong, errN;
  logic [1:0] rxMode;

  always #5 clk = ~clk;

  bus_fail_mgr dut (
    .clk(clk), .rst(rst), .tickEn(tickEn), .normalMode(normalMode),
    .canhHigh(canhHigh), .canlHigh(canlHigh), .domPersist(domPersist),
    .recessive(recessive), .pulseH(pulseH), .pulseL(pulseL),
    .drvHEn(drvHEn), .drvLEn(drvLEn), .rthStrong(rthStrong), .rtlStrong(rtlStrong),
    .rxMode(rxMode), .errN(errN)
  );

  int nRun = 0, nFail = 0, cyc = 0;
  bit tickGate = 1'b1, done = 1'b0;

  // behavioural reference
  int mStage = 0, mCnt = 0, mRec = 0, m6 = 0, c6 = 0, m47 = 0, c47 = 0;
  int mOpen = 0, mDiff = 0, mCons = 0, mLast = 0;   // mLast: 0 none, 1 CANH, 2 CANL high, 3 dominant

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expRx();
    int src;
    bit hOn = (mStage != 0);
    if ((mLast == 1 && hOn) || (mLast == 2 && m6 != 0) || (mLast == 3 && m47 != 0)) src = mLast;
    else if (hOn) src = 1;
    else if (m6 != 0) src = 2;
    else if (m47 != 0) src = 3;
    else src = 0;
    if (src == 1) return (mStage == 2) ? 2 : 1;
    if (src == 0) return 0;
    return 1;
  endfunction

  function automatic int expVec();
    int v;
    v = expRx();
    v = v | ((mStage != 2) << 2) | ((mStage != 2) << 3);
    v = v | ((m6 == 0 && m47 == 0) << 4) | ((m6 == 0 && m47 == 0) << 5);
    v = v | ((mStage == 0 && m6 == 0 && m47 == 0 && mOpen == 0) << 6);
    return v;
  endfunction

  function automatic int dutVec();
    return int'(rxMode) | (int'(drvHEn) << 2) | (int'(rthStrong) << 3) | (int'(drvLEn) << 4)
         | (int'(rtlStrong) << 5) | (int'(errN) << 6);
  endfunction

  task automatic modelStep();
    bit tk = tickEn;
    bit fStep, fRec, f6, f47;
    int lim, d;
    if (rst) begin
      mStage = 0; mCnt = 0; mRec = 0; m6 = 0; c6 = 0; m47 = 0; c47 = 0;
      mOpen = 0; mDiff = 0; mCons = 0; mLast = 0;
      return;
    end
    if (!normalMode) begin
      mCnt = 0; mRec = 0; c6 = 0; c47 = 0; mDiff = 0; mCons = 0;
      return;
    end
    fStep = 0; fRec = 0; f6 = 0; f47 = 0;
    lim = (mStage == 0) ? H1 : H2;
    if (mStage < 2 && canhHigh) begin
      if (tk) begin mCnt++; if (mCnt == lim) begin fStep = 1; mCnt = 0; end end
    end else mCnt = 0;
    if (mStage > 0 && !canhHigh) begin
      if (tk) begin mRec++; if (mRec == HREC) begin fRec = 1; mRec = 0; end end
    end else mRec = 0;
    lim = m6 ? L6R : L6;
    if (m6 ? !canlHigh : canlHigh) begin
      if (tk) begin c6++; if (c6 == lim) begin f6 = 1; c6 = 0; end end
    end else c6 = 0;
    lim = m47 ? DOMR : DOM;
    if (m47 ? recessive : domPersist) begin
      if (tk) begin c47++; if (c47 == lim) begin f47 = 1; c47 = 0; end end
    end else c47 = 0;
    if (mOpen == 0) begin
      d = mDiff + ((pulseH && !pulseL) ? 1 : 0) - ((pulseL && !pulseH) ? 1 : 0);
      if (d == ODIFF || d == -ODIFF) begin mOpen = 1; mDiff = 0; end else mDiff = d;
    end else if (pulseH && pulseL) begin
      mCons++;
      if (mCons == OREC) begin mOpen = 0; mCons = 0; end
    end else if (pulseH || pulseL) mCons = 0;
    if (fStep) begin mStage++; mLast = 1; end
    if (fRec) mStage = 0;
    if (f6) begin if (m6 == 0) mLast = 2; m6 = 1 - m6; end
    if (f47) begin if (m47 == 0) mLast = 3; m47 = 1 - m47; end
  endtask

  task automatic cycle(input int n = 1);
    for (int i = 0; i < n; i++) begin
      tickEn = tickGate && (cyc % 4 != 3);
      @(posedge clk);
      modelStep();
      @(negedge clk);
      chk(dutVec() == expVec(), "R1 R2 R3 R4 R6 R7 R8 R11 model", dutVec(), expVec());
      cyc++;
    end
  endtask

  task automatic pulse(input bit h, input bit l);
    pulseH = h; pulseL = l; cycle();
    pulseH = 0; pulseL = 0; cycle();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cycle(3);
    rst = 0;
    cycle(5);
    chk(rxMode == 0 && errN && drvHEn && drvLEn && rthStrong && rtlStrong, "R1 reset state", dutVec(), 7'h7C);

    // R5: interrupted CANH over-voltage restarts the count
    canhHigh = 1; cycle(200); canhHigh = 0; cycle(1); canhHigh = 1; cycle(200);
    chk(rxMode == 0 && errN, "R5 restart", rxMode, 0);
    canhHigh = 0; cycle(5);

    // R2, R3, R4: two-step CANH escalation and recovery
    canhHigh = 1; cycle(300);
    chk(rxMode == 1 && !errN && drvHEn && rthStrong, "R2 first step", rxMode, 1);
    cycle(300);
    chk(rxMode == 2 && !drvHEn && !rthStrong && drvLEn, "R3 second step", rxMode, 2);
    canhHigh = 0; cycle(100);
    chk(rxMode == 0 && errN && drvHEn && rthStrong, "R4 recovery", rxMode, 0);

    // R6
    canlHigh = 1; cycle(100);
    chk(rxMode == 1 && !drvLEn && !rtlStrong && !errN, "R6 detect", drvLEn, 0);
    canlHigh = 0; cycle(50);
    chk(drvLEn && rtlStrong && errN && rxMode == 0, "R6 recover", drvLEn, 1);

    // R7 with a broken recessive run
    domPersist = 1; cycle(100);
    chk(!drvLEn && !rtlStrong && rxMode == 1 && !errN, "R7 detect", drvLEn, 0);
    domPersist = 0; recessive = 1; cycle(1); recessive = 0; cycle(1);
    chk(!drvLEn, "R5 recessive run broken", drvLEn, 0);
    recessive = 1; cycle(10);
    chk(drvLEn && rtlStrong && errN && rxMode == 0, "R7 recover", drvLEn, 1);
    recessive = 0; cycle(2);

    // R8, R9
    for (int k = 0; k < 3; k++) pulse(1, 0);
    pulse(1, 1);
    chk(errN == 1, "R8 below limit", errN, 1);
    pulse(1, 0);
    chk(!errN && rxMode == 0 && drvHEn && drvLEn && rthStrong && rtlStrong, "R8 open wire", errN, 0);
    for (int k = 0; k < 3; k++) pulse(1, 1);
    pulse(0, 1);
    for (int k = 0; k < 3; k++) pulse(1, 1);
    chk(!errN, "R9 run restarted", errN, 0);
    pulse(1, 1);
    chk(errN == 1, "R9 clear", errN, 1);

    // R10: frozen outside normal mode
    canlHigh = 1; cycle(100);
    normalMode = 0; canlHigh = 0; canhHigh = 1; pulseH = 1; cycle(700); pulseH = 0;
    chk(!drvLEn && rxMode == 1 && drvHEn, "R10 held", drvLEn, 0);
    normalMode = 1; canhHigh = 0; cycle(60);
    chk(drvLEn && errN, "R10 resumed", drvLEn, 1);

    // R11: recency and fallback
    canhHigh = 1; cycle(600);
    canlHigh = 1; cycle(100);
    chk(rxMode == 1, "R11 latest wins", rxMode, 1);
    canlHigh = 0; cycle(60);
    chk(rxMode == 2, "R11 fallback", rxMode, 2);
    canhHigh = 0; cycle(100);
    chk(rxMode == 0 && errN, "R11 all clear", rxMode, 0);

    // R12: no tick, no progress
    tickGate = 0; canhHigh = 1; cycle(500);
    chk(rxMode == 0 && errN, "R12 no tick", rxMode, 0);
    tickGate = 1; cycle(300);
    chk(rxMode == 1, "R12 ticks resume", rxMode, 1);

    // R1: reset in the middle of a failure
    domPersist = 1; cycle(100);
    rst = 1; cycle(2); rst = 0; canhHigh = 0; domPersist = 0; cycle(3);
    chk(rxMode == 0 && errN && drvLEn && rtlStrong && drvHEn, "R1 reset mid-fault", dutVec(), 7'h7C);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule